// File: doc/BRIEF.md
# Circular Host Buffer Pointer Controller

This block decides how far the hardware side of one channel may advance through that channel's buffer in host memory, in a single burst. A descriptor for the channel is fetched from host memory elsewhere. Its fields are presented to this block together with a requested burst length in DWORDs. The descriptor fields are a 4 KB aligned window base, the offset of the last usable DWORD, three policy flags, the user-side offset and wrap flag, the hardware-side offset and wrap flag, and a 3-bit condition field.

One cycle later the block returns the following:
- the physical address where the burst starts;
- how many DWORDs may actually move;
- the hardware offset and wrap flag to write back;
- the updated condition bits;
- whether the buffer was empty or full before the burst.

The hardware side is the producer and the user side is the consumer. A sequencer issues the data transfer and writes the returned pointer fields back into the descriptor. Several requests can be issued back to back, one per cycle.

Offsets are byte offsets in the 4 KB window and are always multiples of 4. The buffer holds N = last/4 + 1 DWORD slots, at offsets 0 through last. Occupancy comes from the two offsets and the two wrap flags.

Top module: `hbuf_ptr_ctrl`

## Requirements
- R1: Results appear on the outputs one clock after `in_valid` is sampled high, with `out_valid` high for exactly that cycle. After reset, `out_valid` is 0 and `out_count` is 0. Requests may arrive on consecutive cycles.
- R2: `out_addr` equals `{in_base, in_hw_off}`, with the base in bits [31:12] and the offset in bits [11:0].
- R3: `out_empty` is 1 when the two offsets are equal and the two wrap flags are equal. `out_full` is 1 when the offsets are equal and the wrap flags differ. Occupancy is hw/4 − user/4 when the flags match, and hw/4 + N − user/4 when they differ. Free space is N minus occupancy.
- R4: With lock set, `out_count` and `out_grant` are 0, and the hardware offset and wrap flag are returned unchanged. Condition bit 2 (refused) is set if the burst is nonzero.
- R5: With overwrite disabled, the grant is min(burst, free space). If the burst is nonzero and the buffer is full, nothing moves and condition bit 2 is set.
- R6: With overwrite enabled, the grant is min(burst, N); free space does not limit it. If the grant exceeds the free space, condition bit 1 (overwrite) is set.
- R7: With stop-enable set, the grant is further limited to the slots remaining up to and including the last offset. If the grant reaches the end, the offset returns to 0, the wrap flag flips, and condition bit 0 (end stop) is set.
- R8: With stop-enable set and condition bit 0 already set on input, nothing moves, the pointer is unchanged, and the condition field is returned as given.
- R9: The new offset is hw + 4·grant. When this passes the last offset it wraps through 0, and the wrap flag flips once.
- R10: Condition bits are sticky: the output is the input field ORed with any newly raised bits.
- R11: `out_grant` is 1 exactly when `out_count` is nonzero. A zero burst moves nothing and raises no condition bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_base | input | 20 | Window base, address bits [31:12] |
| in_last | input | 12 | Offset of the last usable DWORD |
| in_stop_en | input | 1 | 1 = stop at end of buffer, 0 = circular |
| in_ovw_en | input | 1 | 1 = unread data may be overwritten |
| in_lock | input | 1 | 1 = no hardware access |
| in_usr_tog | input | 1 | User wrap flag |
| in_usr_off | input | 12 | User offset |
| in_hw_tog | input | 1 | Hardware wrap flag |
| in_hw_off | input | 12 | Hardware offset |
| in_status | input | 3 | Condition bits: 0 end stop, 1 overwrite, 2 refused |
| in_burst | input | BURST_W | Requested DWORDs |
| out_valid | output | 1 | Result strobe |
| out_grant | output | 1 | Transfer may proceed |
| out_count | output | CNT_W | DWORDs granted |
| out_addr | output | 32 | Physical start address |
| out_hw_off | output | 12 | New hardware offset |
| out_hw_tog | output | 1 | New hardware wrap flag |
| out_status | output | 3 | Updated condition bits |
| out_empty | output | 1 | Buffer empty before the burst |
| out_full | output | 1 | Buffer full before the burst |

## Verification
The bench builds the block with MAX_BURST = 8, so BURST_W is 4. This keeps bursts small enough to land inside a 4-slot buffer, yet still larger than it. That reaches the clamp of an overwriting burst to one lap of the buffer. Other cases use a 64-slot buffer and the full 1024-slot window, which exercise partial grants near full, wrap at the end, and the last slot of the 4 KB window.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int OFF_W  = 12;
    localparam int BASE_W = 20;
    localparam int ADDR_W = BASE_W + OFF_W;
    localparam int SLOT_W = OFF_W - 2;
    localparam int CNT_W  = SLOT_W + 1;

    localparam int ST_END = 0;
    localparam int ST_OVW = 1;
    localparam int ST_REF = 2;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [OFF_W-1:0]  last_off;
        logic              stop_en;
        logic              ovw_en;
        logic              lock;
        logic              usr_tog;
        logic [OFF_W-1:0]  usr_off;
        logic              hw_tog;
        logic [OFF_W-1:0]  hw_off;
        logic [2:0]        status;
    } desc_t;

    typedef struct packed {
        logic              grant;
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] addr;
        logic [OFF_W-1:0]  new_off;
        logic              new_tog;
        logic [2:0]        status;
        logic              empty;
        logic              full;
    } result_t;

    function automatic logic [SLOT_W-1:0] slot_of(input logic [OFF_W-1:0] off);
        return off[OFF_W-1:2];
    endfunction

    function automatic logic [CNT_W-1:0] min_cnt(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/hbp_occupancy.sv
module hbp_occupancy
    import hbp_pkg::*;
(
    input  logic [OFF_W-1:0] hw_off,
    input  logic             hw_tog,
    input  logic [OFF_W-1:0] usr_off,
    input  logic             usr_tog,
    input  logic [CNT_W-1:0] n_slots,
    output logic [CNT_W-1:0] free_slots,
    output logic             is_empty,
    output logic             is_full
);
    logic [CNT_W:0] hs, us, used;
    logic           same_lap;

    always_comb begin
        hs       = (CNT_W+1)'(slot_of(hw_off));
        us       = (CNT_W+1)'(slot_of(usr_off));
        same_lap = (hw_tog == usr_tog);
        if (same_lap) used = hs - us;
        else          used = hs + {1'b0, n_slots} - us;
        free_slots = CNT_W'({1'b0, n_slots} - used);
        is_empty   = (hw_off == usr_off) && same_lap;
        is_full    = (hw_off == usr_off) && !same_lap;
    end

endmodule

// File: rtl/hbp_grant.sv
module hbp_grant
    import hbp_pkg::*;
(
    input  logic             stop_en,
    input  logic             ovw_en,
    input  logic             lock,
    input  logic             stop_seen,
    input  logic [CNT_W-1:0] burst,
    input  logic [CNT_W-1:0] n_slots,
    input  logic [CNT_W-1:0] free_slots,
    input  logic [CNT_W-1:0] hw_slot,
    output logic [CNT_W-1:0] count,
    output logic [2:0]       raise
);
    logic             hold;
    logic [CNT_W-1:0] to_end, space, lim;

    always_comb begin
        hold   = stop_en && stop_seen;
        to_end = n_slots - hw_slot;
        space  = ovw_en ? n_slots : free_slots;
        lim    = min_cnt(burst, space);
        if (stop_en) lim = min_cnt(lim, to_end);
        count  = (lock || hold) ? '0 : lim;

        raise = '0;
        raise[ST_REF] = (burst != '0) &&
                        (lock || (!hold && !ovw_en && free_slots == '0));
        raise[ST_OVW] = !lock && !hold && ovw_en && (count > free_slots);
        raise[ST_END] = !lock && !hold && stop_en && (count != '0) && (count == to_end);
    end

endmodule

// File: rtl/hbp_advance.sv
module hbp_advance
    import hbp_pkg::*;
(
    input  logic [CNT_W-1:0] hw_slot,
    input  logic             hw_tog,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] n_slots,
    output logic [OFF_W-1:0] new_off,
    output logic             new_tog
);
    logic [CNT_W:0] idx;
    logic           wrap;

    always_comb begin
        idx  = {1'b0, hw_slot} + {1'b0, count};
        wrap = (idx >= {1'b0, n_slots});
        if (wrap) idx = idx - {1'b0, n_slots};
        new_off = {idx[SLOT_W-1:0], 2'b00};
        new_tog = hw_tog ^ wrap;
    end

endmodule

// File: rtl/hbuf_ptr_ctrl.sv
module hbuf_ptr_ctrl
    import hbp_pkg::*;
#(
    parameter  int MAX_BURST = 64,
    localparam int BURST_W   = $clog2(MAX_BURST + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [BASE_W-1:0]   in_base,
    input  logic [OFF_W-1:0]    in_last,
    input  logic                in_stop_en,
    input  logic                in_ovw_en,
    input  logic                in_lock,
    input  logic                in_usr_tog,
    input  logic [OFF_W-1:0]    in_usr_off,
    input  logic                in_hw_tog,
    input  logic [OFF_W-1:0]    in_hw_off,
    input  logic [2:0]          in_status,
    input  logic [BURST_W-1:0]  in_burst,
    output logic                out_valid,
    output logic                out_grant,
    output logic [CNT_W-1:0]    out_count,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [OFF_W-1:0]    out_hw_off,
    output logic                out_hw_tog,
    output logic [2:0]          out_status,
    output logic                out_empty,
    output logic                out_full
);
    desc_t            d;
    result_t          nxt, res;
    logic [CNT_W-1:0] n_slots, hw_slot, burst_c, free_slots, count;
    logic [2:0]       raise;
    logic             is_empty, is_full, new_tog;
    logic [OFF_W-1:0] new_off;
    logic             unused_bits;

    assign d = '{base: in_base, last_off: in_last, stop_en: in_stop_en,
                 ovw_en: in_ovw_en, lock: in_lock, usr_tog: in_usr_tog,
                 usr_off: in_usr_off, hw_tog: in_hw_tog, hw_off: in_hw_off,
                 status: in_status};

    assign unused_bits = ^d.last_off[1:0];
    assign n_slots     = CNT_W'(slot_of(d.last_off)) + CNT_W'(1);
    assign hw_slot     = CNT_W'(slot_of(d.hw_off));
    assign burst_c     = CNT_W'(in_burst);

    hbp_occupancy u_occ (
        .hw_off     (d.hw_off),
        .hw_tog     (d.hw_tog),
        .usr_off    (d.usr_off),
        .usr_tog    (d.usr_tog),
        .n_slots    (n_slots),
        .free_slots (free_slots),
        .is_empty   (is_empty),
        .is_full    (is_full)
    );

    hbp_grant u_grant (
        .stop_en    (d.stop_en),
        .ovw_en     (d.ovw_en),
        .lock       (d.lock),
        .stop_seen  (d.status[ST_END]),
        .burst      (burst_c),
        .n_slots    (n_slots),
        .free_slots (free_slots),
        .hw_slot    (hw_slot),
        .count      (count),
        .raise      (raise)
    );

    hbp_advance u_adv (
        .hw_slot (hw_slot),
        .hw_tog  (d.hw_tog),
        .count   (count),
        .n_slots (n_slots),
        .new_off (new_off),
        .new_tog (new_tog)
    );

    always_comb begin
        nxt.grant   = (count != '0);
        nxt.count   = count;
        nxt.addr    = {d.base, d.hw_off};
        nxt.new_off = (count != '0) ? new_off : d.hw_off;
        nxt.new_tog = new_tog;
        nxt.status  = d.status | raise;
        nxt.empty   = is_empty;
        nxt.full    = is_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) res <= nxt;
        end
    end

    assign out_grant  = res.grant;
    assign out_count  = res.count;
    assign out_addr   = res.addr;
    assign out_hw_off = res.new_off;
    assign out_hw_tog = res.new_tog;
    assign out_status = res.status;
    assign out_empty  = res.empty;
    assign out_full   = res.full;

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_start_addr_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_addr == {$past(in_base), $past(in_hw_off)});

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_empty && out_full));

    assert_lock_noaccess_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_lock) |=> (!out_grant && out_count == '0 &&
                                   out_hw_off == $past(in_hw_off) &&
                                   out_hw_tog == $past(in_hw_tog)));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ovw_en) |=> out_count <= $past(free_slots));

    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_stop_en && in_status[ST_END]) |=>
            (out_count == '0 && out_status == $past(in_status)));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_status & $past(in_status)) == $past(in_status)));

endmodule

// File: tb/test_hbuf_ptr_ctrl.sv
module test_hbuf_ptr_ctrl;
    localparam int MB = 8;
    localparam int BW = $clog2(MB + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [19:0] in_base = '0;
    logic [11:0] in_last = '0, in_usr_off = '0, in_hw_off = '0;
    logic        in_stop_en = 1'b0, in_ovw_en = 1'b0, in_lock = 1'b0;
    logic        in_usr_tog = 1'b0, in_hw_tog = 1'b0;
    logic [2:0]  in_status = '0;
    logic [BW-1:0] in_burst = '0;
    logic        out_valid, out_grant, out_hw_tog, out_empty, out_full;
    logic [10:0] out_count;
    logic [31:0] out_addr;
    logic [11:0] out_hw_off;
    logic [2:0]  out_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          grant;
        int          count;
        logic [31:0] addr;
        logic [11:0] off;
        logic        tog;
        logic [2:0]  st;
        logic        empty;
        logic        full;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    hbuf_ptr_ctrl #(.MAX_BURST(MB)) i_hbuf_ptr_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_base(in_base),
        .in_last(in_last), .in_stop_en(in_stop_en), .in_ovw_en(in_ovw_en),
        .in_lock(in_lock), .in_usr_tog(in_usr_tog), .in_usr_off(in_usr_off),
        .in_hw_tog(in_hw_tog), .in_hw_off(in_hw_off), .in_status(in_status),
        .in_burst(in_burst), .out_valid(out_valid), .out_grant(out_grant),
        .out_count(out_count), .out_addr(out_addr), .out_hw_off(out_hw_off),
        .out_hw_tog(out_hw_tog), .out_status(out_status),
        .out_empty(out_empty), .out_full(out_full)
    );

    task automatic send(input logic [19:0] base, input int last,
                        input bit stop, input bit ovw, input bit lock,
                        input bit ut, input int uo, input bit ht, input int ho,
                        input logic [2:0] st, input int burst, input string tag);
        exp_t e;
        int n, hs, us, used, free_s, toend, lim, space, cnt, idx;
        bit hold, tog;
        logic [2:0] nst;
        n    = last / 4 + 1;
        hs   = ho / 4;
        us   = uo / 4;
        used = (ht == ut) ? hs - us : hs + n - us;
        free_s = n - used;
        hold = stop && st[0];
        toend = n - hs;
        space = ovw ? n : free_s;
        lim  = (burst < space) ? burst : space;
        if (stop && toend < lim) lim = toend;
        cnt  = (lock || hold) ? 0 : lim;
        nst  = st;
        if (burst != 0 && (lock || (!hold && !ovw && free_s == 0))) nst[2] = 1'b1;
        if (!lock && !hold && ovw && cnt > free_s) nst[1] = 1'b1;
        if (!lock && !hold && stop && cnt != 0 && cnt == toend) nst[0] = 1'b1;
        idx = hs + cnt;
        tog = ht;
        if (idx >= n) begin idx = idx - n; tog = !tog; end
        e.grant = (cnt != 0);
        e.count = cnt;
        e.addr  = {base, 12'(ho)};
        e.off   = 12'(idx * 4);
        e.tog   = tog;
        e.st    = nst;
        e.empty = (hs == us) && (ht == ut);
        e.full  = (hs == us) && (ht != ut);
        e.tag   = tag;
        sb.push_back(e);
        in_valid = 1'b1; in_base = base; in_last = 12'(last);
        in_stop_en = stop; in_ovw_en = ovw; in_lock = lock;
        in_usr_tog = ut; in_usr_off = 12'(uo); in_hw_tog = ht; in_hw_off = 12'(ho);
        in_status = st; in_burst = BW'(burst);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1: unexpected result, actual out_valid=1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (int'(out_grant) != e.grant || int'(out_count) != e.count ||
                    out_addr != e.addr || out_hw_off != e.off ||
                    out_hw_tog != e.tog || out_status != e.st ||
                    out_empty != e.empty || out_full != e.full) begin
                    errors++;
                    $display("FAIL %s: actual g=%0d n=%0d a=%h off=%h t=%0d st=%b e=%0d f=%0d expected g=%0d n=%0d a=%h off=%h t=%0d st=%b e=%0d f=%0d",
                        e.tag, out_grant, out_count, out_addr, out_hw_off, out_hw_tog,
                        out_status, out_empty, out_full, e.grant, e.count, e.addr,
                        e.off, e.tog, e.st, e.empty, e.full);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_count !== '0) begin
            errors++;
            $display("FAIL R1 reset: actual valid=%b count=%0d expected 0 0", out_valid, out_count);
        end
        // R2 R3 empty buffer, plain grant
        send(20'hABCDE, 'h0FC, 0, 0, 0, 0, 'h010, 0, 'h010, 3'b000, 5, "R2_R3_empty");
        // R3 R5 full buffer refused
        send(20'h12345, 'h0FC, 0, 0, 0, 1, 'h040, 0, 'h040, 3'b000, 3, "R3_R5_full");
        // R5 partial grant limited by free space
        send(20'h00001, 'h0FC, 0, 0, 0, 1, 'h010, 0, 'h000, 3'b000, 7, "R5_partial");
        // R9 circular wrap with toggle flip
        send(20'h00002, 'h0FC, 0, 0, 0, 0, 'h0F0, 0, 'h0F8, 3'b000, 5, "R9_wrap");
        // R7 stop at end
        send(20'h00003, 'h0FC, 1, 0, 0, 0, 'h0F0, 0, 'h0F8, 3'b000, 5, "R7_stop");
        // R8 already stopped
        send(20'h00004, 'h0FC, 1, 0, 0, 0, 'h0F0, 0, 'h0F8, 3'b001, 5, "R8_held");
        // R4 lock
        send(20'h00005, 'h0FC, 0, 0, 1, 0, 'h000, 1, 'h020, 3'b000, 4, "R4_lock");
        // R6 overwrite on a 4-slot full buffer, clamped to one lap
        send(20'h00006, 'h00C, 0, 1, 0, 1, 'h004, 0, 'h004, 3'b000, 8, "R6_ovw_clamp");
        // R10 sticky bits
        send(20'h00007, 'h0FC, 0, 0, 0, 0, 'h010, 0, 'h010, 3'b010, 5, "R10_sticky");
        // R11 zero burst on a full buffer
        send(20'h00008, 'h0FC, 0, 0, 0, 1, 'h040, 0, 'h040, 3'b000, 0, "R11_zero");
        // R9 R5 full 4 KB window, last slot
        send(20'hFFFFF, 'hFFC, 0, 0, 0, 0, 'h000, 0, 'hFFC, 3'b000, 3, "R9_window");
        // R7 R5 stop with overwrite disabled, free space binds first
        send(20'h00009, 'h0FC, 1, 0, 0, 1, 'h0F4, 0, 'h0F0, 3'b000, 8, "R7_R5_combo");
        // R6 overwrite without exceeding free space
        send(20'h0000A, 'h03C, 0, 1, 0, 0, 'h000, 0, 'h000, 3'b000, 6, "R6_no_ovw");
        // R4 lock with zero burst raises nothing
        send(20'h0000B, 'h0FC, 0, 0, 1, 0, 'h000, 0, 'h000, 3'b000, 0, "R4_lock_zero");
        // R1 back-to-back stream
        for (int k = 0; k < 6; k++)
            send(20'h0C0DE, 'h01C, 0, 0, 0, 0, 'h000, 0, (k * 4) % 32, 3'b000, 1,
                 "R1_stream");
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1: actual %0d results missing expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule